// File: doc/BRIEF.md
# One-shot / Periodic Interval Timer with Prescale Extension

This block is a general-purpose interval timer. Its count is 24 bits wide by default: a 16-bit timer part with an 8-bit prescale part above it. The count runs up or down, one step per clock. It works either as a one-shot, which stops after one expiry, or as a periodic timer, which reloads and runs on.

Software reaches the block through a plain register port with a one-cycle write strobe and a combinational read. Through that port it sets the interval, overwrites the live count, arms a match compare and sets control bits. It also masks and clears the two interrupt sources: expiry and match. Rewrites of the interval and of the match value take effect at run time. Control bits choose whether a rewrite applies at once or waits until the next expiry.

Periodic mode can latch the count at each expiry into a snapshot register, so the handler can measure its own latency. A debug-halt input can freeze the count unless an override bit is set. A one-clock converter-start pulse marks each expiry.

The block has no streaming data path, so there is no valid/ready handshake and no back-pressure. All pins are plain control and status.

Top module: `gp_interval_timer`

## Requirements
- R1: After reset, every register reads 0 and every status pin is low. Register map: 0 interval timer part, 1 interval prescale part, 2 live count timer part, 3 live count prescale part, 4 match timer part, 5 match prescale part, 6 control, 7 mask, 8 clear (write only), 9 snapshot timer part, 10 snapshot prescale part. Unmapped addresses read 0.
- R2: Control bits: 0 enable, 1 count-up, 2 periodic, 3 snapshot, 4 match enable, 5 deferred load, 6 deferred match, 7 stall, 8 stall override, 9 converter trigger enable. When enabled and counting down, the count falls by one per clock. A cycle in which the count is 0 is an expiry, and the next edge loads the combined interval {prescale, timer}.
- R3: When counting up, the count rises by one per clock. A cycle in which the count equals the combined interval is an expiry, and the next edge loads 0 into both parts.
- R4: In one-shot mode (bit 2 clear), an expiry reloads the count as in R2/R3, clears control bit 0, and the count then holds. In periodic mode counting resumes at once.
- R5: With bits 2 and 3 both set, the count present in an expiry cycle is latched into the snapshot registers. In one-shot mode the snapshot registers never change.
- R6: An expiry sets the raw expiry flag one edge later. The flag stays set until a write to the clear register with bit 0 set. If the clear and a new expiry fall on the same edge, the flag stays set. The masked expiry flag is the raw flag AND mask bit 0.
- R7: With control bit 4 set, a cycle in which the running count equals the combined match value sets the raw match flag one edge later. The flag is cleared by a write with clear bit 1 and masked by mask bit 1. With control bit 4 clear, the match flag is never set.
- R8: With control bit 9 set, each expiry produces a converter trigger pulse exactly one clock wide on the following cycle. A match never produces one.
- R9: While counting down with bit 5 clear, a write to either interval register loads the new combined interval into the count on the next edge. With bit 5 set, the count is untouched and the new interval is used at the next reload.
- R10: While counting up, an interval write moves the expiry point from the next cycle on.
- R11: A write to address 2 or 3 replaces that part of the live count on the next edge, and counting continues from there in the current direction.
- R12: With bit 6 clear, a match-register write takes effect on the next edge. With bit 6 set, the compared value changes only at the edge that follows the next expiry.
- R13: With bit 7 set, bit 8 clear and the debug-halt input high, the count freezes, and it resumes when halt falls. With bit 8 set, halt has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_addr | input | 4 | Write register address |
| wr_data | input | 16 | Write data |
| rd_addr | input | 4 | Read register address |
| rd_data | output | 16 | Combinational read data |
| dbg_halt | input | 1 | Debug halt request |
| to_raw | output | 1 | Raw expiry flag |
| to_masked | output | 1 | Masked expiry flag |
| match_raw | output | 1 | Raw match flag |
| match_masked | output | 1 | Masked match flag |
| adc_trig | output | 1 | One-clock converter trigger pulse |

## Verification
The hardest cases to reach from the ports are the ones that must land on one exact edge. The first is a clear write arriving on the same edge as a new expiry. The second is a deferred match rewrite that must stay inactive through one whole period and switch on only at the edge after expiry. The stimulus reaches both by counting clock edges from the write that enables the timer, using short intervals such as 5, so that the write strobe is placed on the expiry edge itself. The expected flags, counts and trigger are then sampled one edge before and after each event.

// File: rtl/gpt_pkg.sv
package gpt_pkg;
  localparam int AW     = 4;
  localparam int CTRL_W = 10;

  localparam logic [AW-1:0] A_ILD    = 4'd0;
  localparam logic [AW-1:0] A_PLD    = 4'd1;
  localparam logic [AW-1:0] A_CNT_T  = 4'd2;
  localparam logic [AW-1:0] A_CNT_P  = 4'd3;
  localparam logic [AW-1:0] A_MAT_T  = 4'd4;
  localparam logic [AW-1:0] A_MAT_P  = 4'd5;
  localparam logic [AW-1:0] A_CTRL   = 4'd6;
  localparam logic [AW-1:0] A_IMASK  = 4'd7;
  localparam logic [AW-1:0] A_ICLR   = 4'd8;
  localparam logic [AW-1:0] A_SNAP_T = 4'd9;
  localparam logic [AW-1:0] A_SNAP_P = 4'd10;

  // first field is the most significant bit; enable sits at bit 0
  typedef struct packed {
    logic adc_te;
    logic rtc_ovr;
    logic stall;
    logic mdefer;
    logic ldefer;
    logic mie;
    logic snap;
    logic periodic;
    logic up;
    logic en;
  } ctrl_t;
endpackage

// File: rtl/gpt_regs.sv
module gpt_regs import gpt_pkg::*; #(
  parameter int TW = 16,
  parameter int PW = 8,
  localparam int CW = TW + PW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [TW-1:0] wr_data,
  input  logic          to_evt,
  output ctrl_t         ctrl,
  output logic [1:0]    imask,
  output logic [1:0]    iclr,
  output logic [CW-1:0] ld_val,
  output logic [CW-1:0] ld_next,
  output logic          force_ld,
  output logic [CW-1:0] mat_val,
  output logic [CW-1:0] mat_pend,
  output logic [1:0]    val_wr
);
  logic [TW-1:0] ild_q, mt_pend_q, mt_cur_q;
  logic [PW-1:0] pld_q, mp_pend_q, mp_cur_q;
  logic wr_ild, wr_pld, wr_mt, wr_mp, wr_ctrl, wr_mask, wr_clr;

  assign wr_ild  = wr_en && (wr_addr == A_ILD);
  assign wr_pld  = wr_en && (wr_addr == A_PLD);
  assign wr_mt   = wr_en && (wr_addr == A_MAT_T);
  assign wr_mp   = wr_en && (wr_addr == A_MAT_P);
  assign wr_ctrl = wr_en && (wr_addr == A_CTRL);
  assign wr_mask = wr_en && (wr_addr == A_IMASK);
  assign wr_clr  = wr_en && (wr_addr == A_ICLR);

  assign val_wr   = {wr_en && (wr_addr == A_CNT_P), wr_en && (wr_addr == A_CNT_T)};
  assign iclr     = wr_clr ? wr_data[1:0] : 2'b00;
  assign ld_val   = {pld_q, ild_q};
  assign ld_next  = {wr_pld ? wr_data[PW-1:0] : pld_q, wr_ild ? wr_data : ild_q};
  assign force_ld = (wr_ild || wr_pld) && !ctrl.up && !ctrl.ldefer;
  assign mat_val  = {mp_cur_q, mt_cur_q};
  assign mat_pend = {mp_pend_q, mt_pend_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ild_q     <= '0;
      pld_q     <= '0;
      mt_pend_q <= '0;
      mp_pend_q <= '0;
      mt_cur_q  <= '0;
      mp_cur_q  <= '0;
      ctrl      <= '0;
      imask     <= '0;
    end else begin
      if (wr_ild)  ild_q     <= wr_data;
      if (wr_pld)  pld_q     <= wr_data[PW-1:0];
      if (wr_mt)   mt_pend_q <= wr_data;
      if (wr_mp)   mp_pend_q <= wr_data[PW-1:0];
      if (wr_mask) imask     <= wr_data[1:0];
      if (!ctrl.mdefer) begin
        if (wr_mt) mt_cur_q <= wr_data;
        if (wr_mp) mp_cur_q <= wr_data[PW-1:0];
      end else if (to_evt) begin
        mt_cur_q <= mt_pend_q;
        mp_cur_q <= mp_pend_q;
      end
      if (wr_ctrl)                          ctrl    <= ctrl_t'(wr_data[CTRL_W-1:0]);
      else if (to_evt && !ctrl.periodic)    ctrl.en <= 1'b0;
    end
  end

  AST_ONESHOT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (to_evt && !ctrl.periodic && !wr_ctrl) |=> !ctrl.en); // R4
  AST_MATCH_DEFER: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.mdefer && !to_evt) |=> $stable(mat_val)); // R12
endmodule

// File: rtl/gpt_core.sv
module gpt_core #(
  parameter int TW = 16,
  parameter int PW = 8,
  localparam int CW = TW + PW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          up,
  input  logic          periodic,
  input  logic          snap_en,
  input  logic          mie,
  input  logic          stall,
  input  logic          rtc_ovr,
  input  logic          dbg_halt,
  input  logic [CW-1:0] ld_val,
  input  logic [CW-1:0] ld_next,
  input  logic          force_ld,
  input  logic [CW-1:0] mat_val,
  input  logic [1:0]    val_wr,
  input  logic [TW-1:0] wr_data,
  output logic [CW-1:0] cnt,
  output logic [CW-1:0] snap,
  output logic          to_evt,
  output logic          mt_evt
);
  logic          frozen, active, at_end;
  logic [CW-1:0] cnt_d;

  assign frozen = stall && !rtc_ovr && dbg_halt;
  assign active = en && !frozen;
  assign at_end = up ? (cnt == ld_val) : (cnt == '0);
  assign to_evt = active && at_end;
  assign mt_evt = active && mie && (cnt == mat_val);

  always_comb begin
    cnt_d = cnt;
    if (to_evt)      cnt_d = up ? '0 : ld_val;
    else if (active) cnt_d = up ? cnt + CW'(1) : cnt - CW'(1);
    if (force_ld)    cnt_d = ld_next;
    if (val_wr[0])   cnt_d[TW-1:0]  = wr_data;
    if (val_wr[1])   cnt_d[CW-1:TW] = wr_data[PW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      snap <= '0;
    end else begin
      cnt <= cnt_d;
      if (to_evt && periodic && snap_en) snap <= cnt;
    end
  end

  AST_DOWN_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (to_evt && !up && !force_ld && (val_wr == 2'b00)) |=> (cnt == $past(ld_val))); // R2
  AST_UP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (to_evt && up && !force_ld && (val_wr == 2'b00)) |=> (cnt == '0)); // R3
  AST_SNAP_ONESHOT: assert property (@(posedge clk) disable iff (!rst_n)
    !periodic |=> $stable(snap)); // R5
  AST_FORCE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (force_ld && (val_wr == 2'b00)) |=> (cnt == $past(ld_next))); // R9
  AST_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && !rtc_ovr && dbg_halt && !force_ld && (val_wr == 2'b00)) |=> $stable(cnt)); // R13
endmodule

// File: rtl/gpt_irq.sv
module gpt_irq #(
  parameter int NCH = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] evt,
  input  logic [NCH-1:0] clr,
  input  logic [NCH-1:0] mask,
  input  logic           adc_en,
  output logic [NCH-1:0] raw,
  output logic [NCH-1:0] masked,
  output logic           adc_trig
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw      <= '0;
      adc_trig <= 1'b0;
    end else begin
      raw      <= evt | (raw & ~clr);
      adc_trig <= evt[0] && adc_en && !adc_trig;
    end
  end

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    assign masked[ch] = raw[ch] & mask[ch];

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      evt[ch] |=> raw[ch]); // R6
    AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (raw[ch] && !clr[ch]) |=> raw[ch]); // R6
  end

  AST_ADC_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    adc_trig |-> $past(evt[0] && adc_en)); // R8
endmodule

// File: rtl/gp_interval_timer.sv
module gp_interval_timer import gpt_pkg::*; #(
  parameter int TW = 16,
  parameter int PW = 8,
  localparam int CW = TW + PW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [TW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [TW-1:0] rd_data,
  input  logic          dbg_halt,
  output logic          to_raw,
  output logic          to_masked,
  output logic          match_raw,
  output logic          match_masked,
  output logic          adc_trig
);
  ctrl_t             ctrl;
  logic [CTRL_W-1:0] ctrl_bits;
  logic [1:0]        imask, iclr, val_wr, raw, masked;
  logic [CW-1:0]     ld_val, ld_next, mat_val, mat_pend, cnt, snap;
  logic              force_ld, to_evt, mt_evt;

  gpt_regs #(.TW(TW), .PW(PW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .to_evt(to_evt), .ctrl(ctrl), .imask(imask), .iclr(iclr),
    .ld_val(ld_val), .ld_next(ld_next), .force_ld(force_ld),
    .mat_val(mat_val), .mat_pend(mat_pend), .val_wr(val_wr)
  );

  gpt_core #(.TW(TW), .PW(PW)) u_core (
    .clk(clk), .rst_n(rst_n), .en(ctrl.en), .up(ctrl.up), .periodic(ctrl.periodic),
    .snap_en(ctrl.snap), .mie(ctrl.mie), .stall(ctrl.stall), .rtc_ovr(ctrl.rtc_ovr),
    .dbg_halt(dbg_halt), .ld_val(ld_val), .ld_next(ld_next), .force_ld(force_ld),
    .mat_val(mat_val), .val_wr(val_wr), .wr_data(wr_data),
    .cnt(cnt), .snap(snap), .to_evt(to_evt), .mt_evt(mt_evt)
  );

  gpt_irq #(.NCH(2)) u_irq (
    .clk(clk), .rst_n(rst_n), .evt({mt_evt, to_evt}), .clr(iclr), .mask(imask),
    .adc_en(ctrl.adc_te), .raw(raw), .masked(masked), .adc_trig(adc_trig)
  );

  assign to_raw       = raw[0];
  assign match_raw    = raw[1];
  assign to_masked    = masked[0];
  assign match_masked = masked[1];
  assign ctrl_bits    = ctrl;

  always_comb begin
    case (rd_addr)
      A_ILD:    rd_data = ld_val[TW-1:0];
      A_PLD:    rd_data = TW'(ld_val[CW-1:TW]);
      A_CNT_T:  rd_data = cnt[TW-1:0];
      A_CNT_P:  rd_data = TW'(cnt[CW-1:TW]);
      A_MAT_T:  rd_data = mat_pend[TW-1:0];
      A_MAT_P:  rd_data = TW'(mat_pend[CW-1:TW]);
      A_CTRL:   rd_data = TW'(ctrl_bits);
      A_IMASK:  rd_data = TW'(imask);
      A_SNAP_T: rd_data = snap[TW-1:0];
      A_SNAP_P: rd_data = TW'(snap[CW-1:TW]);
      default:  rd_data = '0;
    endcase
  end

  AST_MATCH_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(match_raw) |-> $past(ctrl.mie)); // R7
endmodule

// File: tb/gp_interval_timer_test.sv
`timescale 1ns/100ps
module gp_interval_timer_test;
  import gpt_pkg::*;

  localparam logic [15:0] C_EN = 16'h001, C_UP = 16'h002, C_PER = 16'h004, C_SNAP = 16'h008;
  localparam logic [15:0] C_MIE = 16'h010, C_LDEF = 16'h020, C_MDEF = 16'h040;
  localparam logic [15:0] C_STALL = 16'h080, C_RTC = 16'h100, C_ADC = 16'h200;

  logic        clk = 1'b0;
  logic        rst_n, wr_en, dbg_halt;
  logic [3:0]  wr_addr, rd_addr;
  logic [15:0] wr_data, rd_data;
  logic        to_raw, to_masked, match_raw, match_masked, adc_trig;
  logic [4:0]  pins;
  int          checks = 0;
  int          errors = 0;
  bit          done = 0;

  logic [16:0] exp_q[$];
  string       tag_q[$];
  event        sb_ev;

  always #2.5 clk = ~clk;

  gp_interval_timer uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .dbg_halt(dbg_halt),
    .to_raw(to_raw), .to_masked(to_masked), .match_raw(match_raw),
    .match_masked(match_masked), .adc_trig(adc_trig)
  );

  // pin vector: {adc_trig, match_masked, match_raw, to_masked, to_raw}
  assign pins = {adc_trig, match_masked, match_raw, to_masked, to_raw};

  // monitor: pops the expected item and compares it with what the design shows now
  always @(sb_ev) begin
    logic [16:0] it;
    logic [15:0] got;
    string       t;
    it = exp_q.pop_front();
    t  = tag_q.pop_front();
    got = it[16] ? {11'd0, pins} : rd_data;
    checks++;
    if (got !== it[15:0]) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", t, got, it[15:0]);
    end
  end

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk_reg(input logic [3:0] a, input logic [15:0] e, input string t);
    rd_addr = a;
    #0.2;
    exp_q.push_back({1'b0, e});
    tag_q.push_back(t);
    -> sb_ev;
    #0.2;
  endtask

  task automatic chk_pins(input logic [4:0] e, input string t);
    #0.2;
    exp_q.push_back({1'b1, 11'd0, e});
    tag_q.push_back(t);
    -> sb_ev;
    #0.2;
  endtask

  initial begin
    #1000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0; dbg_halt = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk_reg(A_CNT_T, 16'd0, "R1 count after reset");
    chk_reg(A_CTRL, 16'd0, "R1 control after reset");
    chk_reg(A_SNAP_T, 16'd0, "R1 snapshot after reset");
    chk_pins(5'h00, "R1 pins after reset");

    // down periodic with trigger
    wr(A_IMASK, 16'h1);
    wr(A_ILD, 16'd5);
    chk_reg(A_CNT_T, 16'd5, "R9 immediate load on interval write");
    wr(A_CTRL, C_EN | C_PER | C_ADC);
    idle(5);
    chk_reg(A_CNT_T, 16'd0, "R2 down count reaches zero");
    chk_pins(5'h00, "R2 no flag during expiry cycle");
    idle(1);
    chk_reg(A_CNT_T, 16'd5, "R2 reload after expiry");
    chk_pins(5'h13, "R6 R8 flag and trigger after expiry");
    idle(1);
    chk_reg(A_CNT_T, 16'd4, "R4 periodic keeps counting");
    chk_pins(5'h03, "R8 trigger one clock wide, R6 flag sticky");
    wr(A_ICLR, 16'h1);
    chk_pins(5'h00, "R6 clear drops flag");
    idle(3);
    wr(A_ICLR, 16'h1);
    chk_pins(5'h13, "R6 set wins over clear on same edge");
    wr(A_ICLR, 16'h1);
    chk_pins(5'h00, "R6 later clear");
    wr(A_CNT_T, 16'd20);
    chk_reg(A_CNT_T, 16'd20, "R11 value write");
    idle(1);
    chk_reg(A_CNT_T, 16'd19, "R11 counting continues from written value");
    wr(A_ILD, 16'd9);
    chk_reg(A_CNT_T, 16'd9, "R9 running interval write loads count");
    wr(A_CTRL, 16'h0);

    // deferred load
    wr(A_ICLR, 16'h3);
    wr(A_ILD, 16'd5);
    wr(A_CTRL, C_EN | C_PER | C_LDEF);
    wr(A_ILD, 16'd9);
    chk_reg(A_CNT_T, 16'd4, "R9 deferred write leaves count");
    idle(4);
    chk_reg(A_CNT_T, 16'd0, "R9 deferred old period runs out");
    idle(1);
    chk_reg(A_CNT_T, 16'd9, "R9 deferred value used at reload");
    wr(A_CTRL, 16'h0);

    // stall and override
    wr(A_ILD, 16'd5);
    wr(A_CTRL, C_EN | C_PER | C_STALL);
    idle(1);
    dbg_halt = 1'b1;
    idle(3);
    chk_reg(A_CNT_T, 16'd4, "R13 halt freezes count");
    dbg_halt = 1'b0;
    idle(1);
    chk_reg(A_CNT_T, 16'd3, "R13 count resumes after halt");
    wr(A_CTRL, C_EN | C_PER | C_STALL | C_RTC);
    dbg_halt = 1'b1;
    idle(1);
    chk_reg(A_CNT_T, 16'd1, "R13 override ignores halt");
    dbg_halt = 1'b0;
    wr(A_CTRL, 16'h0);

    // up one-shot with snapshot bit
    wr(A_ICLR, 16'h3);
    wr(A_CTRL, C_UP);
    wr(A_ILD, 16'd3);
    wr(A_CNT_T, 16'd0);
    wr(A_CTRL, C_EN | C_UP | C_SNAP);
    idle(3);
    chk_reg(A_CNT_T, 16'd3, "R3 up count reaches interval");
    chk_pins(5'h00, "R3 no flag before expiry edge");
    idle(1);
    chk_reg(A_CNT_T, 16'd0, "R3 up reload to zero");
    chk_reg(A_CTRL, C_UP | C_SNAP, "R4 one-shot clears enable");
    chk_pins(5'h03, "R3 expiry flag in up mode");
    idle(2);
    chk_reg(A_CNT_T, 16'd0, "R4 one-shot holds");
    chk_reg(A_SNAP_T, 16'd0, "R5 no snapshot in one-shot");

    // up periodic, interval moved while running
    wr(A_ICLR, 16'h3);
    wr(A_ILD, 16'd10);
    wr(A_CTRL, C_EN | C_UP | C_PER);
    wr(A_ILD, 16'd3);
    idle(2);
    chk_reg(A_CNT_T, 16'd3, "R10 count at moved expiry point");
    chk_pins(5'h00, "R10 no flag yet");
    idle(1);
    chk_reg(A_CNT_T, 16'd0, "R10 expiry at new interval");
    chk_pins(5'h03, "R10 flag from moved expiry");
    wr(A_CTRL, C_UP);

    // snapshot with prescale part
    wr(A_ICLR, 16'h3);
    wr(A_PLD, 16'd1);
    wr(A_ILD, 16'd2);
    wr(A_CNT_P, 16'd1);
    wr(A_CNT_T, 16'd0);
    wr(A_CTRL, C_EN | C_UP | C_PER | C_SNAP);
    idle(3);
    chk_reg(A_CNT_T, 16'd0, "R3 timer part zero after combined expiry");
    chk_reg(A_CNT_P, 16'd0, "R3 prescale part zero after combined expiry");
    chk_reg(A_SNAP_T, 16'd2, "R5 snapshot timer part");
    chk_reg(A_SNAP_P, 16'd1, "R5 snapshot prescale part");
    wr(A_CTRL, C_UP);
    wr(A_PLD, 16'd0);
    wr(A_CTRL, 16'h0);

    // match disabled, then deferred match update
    wr(A_ICLR, 16'h3);
    wr(A_IMASK, 16'h3);
    wr(A_MAT_T, 16'd2);
    wr(A_ILD, 16'd5);
    wr(A_CTRL, C_EN | C_PER | C_ADC);
    idle(6);
    chk_pins(5'h13, "R7 match flag stays clear without enable");
    wr(A_CTRL, 16'h0);
    wr(A_ICLR, 16'h3);
    wr(A_ILD, 16'd5);
    wr(A_CTRL, C_MIE | C_MDEF);
    wr(A_MAT_T, 16'd4);
    wr(A_CTRL, C_EN | C_PER | C_MIE | C_MDEF | C_ADC);
    idle(4);
    chk_pins(5'h0C, "R7 R8 match flag set, no trigger on match");
    wr(A_ICLR, 16'h2);
    chk_pins(5'h00, "R7 match clear");
    idle(1);
    chk_pins(5'h13, "R8 trigger on expiry");
    idle(1);
    chk_pins(5'h03, "R12 before new match point");
    idle(1);
    chk_pins(5'h0F, "R12 deferred match value active after expiry");
    wr(A_ICLR, 16'h2);
    idle(2);
    chk_pins(5'h03, "R12 old match value no longer compared");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule